// File: doc/BRIEF.md
# 384-bit ARX Permutation Core

This block applies a chosen number of steps of a 384-bit add-rotate-xor permutation to a state held in twelve 32-bit words. The words are grouped into six branches. Each branch is a pair (x, y). A caller places the state and a step count on the inputs and pulses `start` while the core is idle. The core then works through the steps and raises `done` with the permuted state on `state_out`. It holds that result until the next accepted start.

Each step has three parts. First, the step index and a constant from an eight-word table are folded into the first two y words. Next, an ARX box keyed with a per-branch constant runs on all six branches. Finally, a mixing layer folds the left half into the right half and reorders the branches. The datapath has one ARX-box instance, which handles one branch per cycle. A seventh cycle applies the mixing layer, so one step takes seven cycles.

Top module: `perm384_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears `busy`, `done` and `state_out` to zero.
- R2: A `start` pulse seen while `busy` is low loads `state_in` and `steps`, and clears `done`. Word k of the state is `state_in[32k+31:32k]`, and branch i is x = word 2i, y = word 2i+1. For a nonzero step count, `busy` is high from the next cycle.
- R3: A step count of zero gives `done` high and `state_out` equal to the loaded state in the cycle after the accepted start, and `busy` stays low.
- R4: At the start of step s (s counting from 0), y0 is XORed with table entry s mod 8 and y1 is XORed with s. The table is 0xB7E15162, 0xBF715880, 0x38B4DA56, 0x324E7738, 0xBB1185EB, 0x4F7C7B57, 0xCFBFA1C8, 0xC2B3293D.
- R5: Branch i (0 to 5) is passed through the ARX box with table entry i as its key. The box has four rounds with rotate-right amounts (31,24), (17,17), (0,31), (24,16). Each round does x += rotr(y,a); y ^= rotr(x,b); x ^= key.
- R6: The mixing layer works in three stages:
  - With ell(t) = rotr(t ^ (t << 16), 16), it forms tx = x0^x1^x2 and ty = y0^y1^y2.
  - For each right branch j in 3..5, it sets x_j ^= ell(ty) ^ x_(j-3) and y_j ^= ell(tx) ^ y_(j-3).
  - The new branches 0,1,2 are the updated branches 4,5,3, and the new branches 3,4,5 are the old branches 0,1,2.
- R7: For a step count N > 0, `busy` is high for exactly 7N cycles. `done` rises as `busy` falls, and the two are never high together.
- R8: A `start` pulse while `busy` is high is ignored. The run in progress finishes with the result of its original inputs.
- R9: Once `done` is high, it stays high and `state_out` stays unchanged until the next accepted start.
- R10: Step counts above eight wrap the table index modulo 8 and keep injecting the full step index into y1. The port carries counts up to 2^STEP_W - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| steps | input | STEP_W | Number of steps to apply |
| state_in | input | 384 | State to permute, word k at bits 32k+31:32k |
| state_out | output | 384 | Current or final state, same packing |
| busy | output | 1 | A run is in progress |
| done | output | 1 | `state_out` holds the finished result |

## Verification
A wrong branch select, key, rotation or injection shows up in `state_out` as soon as `done` rises. One step already spreads the error across most of the state through the mixing layer. A fault in the step counter or its end compare shows at the ports in two ways: `busy` lasts a number of cycles other than 7N, and runs longer than eight steps give wrong results. A run that accepts a start while busy returns the result of the wrong input. A result register that is not held lets `state_out` drift while `done` is high.

// File: rtl/perm384_pkg.sv
// Package: shared widths, word type, rotate helper and the eight-word key table.
// Assumes 32-bit words; the table index is three bits wide.
package perm384_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned N_BR    = 6;
    localparam int unsigned N_WORDS = 2 * N_BR;
    localparam int unsigned STATE_W = WORD_W * N_WORDS;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

    // Rotate a word right by n places (n below 32).
    function automatic word_t rotr(word_t v, int unsigned n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction

    // Key table lookup used for both branch keys and step injection.
    function automatic word_t key_word(logic [2:0] idx);
        case (idx)
            3'd0: return 32'hB7E15162;
            3'd1: return 32'hBF715880;
            3'd2: return 32'h38B4DA56;
            3'd3: return 32'h324E7738;
            3'd4: return 32'hBB1185EB;
            3'd5: return 32'h4F7C7B57;
            3'd6: return 32'hCFBFA1C8;
            default: return 32'hC2B3293D;
        endcase
    endfunction
endpackage

// File: rtl/perm384_arx_box.sv
// Module: one keyed four-round ARX box, purely combinational.
// Assumes the caller supplies the key of the branch being processed.
module perm384_arx_box
    import perm384_pkg::*;
(
    input  word_t x_in,
    input  word_t y_in,
    input  word_t key,
    output word_t x_out,
    output word_t y_out
);
    localparam int unsigned N_RND = 4;
    localparam int unsigned ROT_A [N_RND] = '{31, 17, 0, 24};
    localparam int unsigned ROT_B [N_RND] = '{24, 17, 31, 16};

    word_t xs [N_RND+1];
    word_t ys [N_RND+1];

    assign xs[0] = x_in;
    assign ys[0] = y_in;

    // Chain of identical rounds differing only in rotate amounts.
    for (genvar r = 0; r < N_RND; r++) begin : g_rnd
        word_t xa;
        assign xa        = xs[r] + rotr(ys[r], ROT_A[r]);
        assign ys[r+1]   = ys[r] ^ rotr(xa, ROT_B[r]);
        assign xs[r+1]   = xa ^ key;
    end

    assign x_out = xs[N_RND];
    assign y_out = ys[N_RND];
endmodule

// File: rtl/perm384_mix.sv
// Module: mixing layer, folds the left half into the right half and reorders branches.
// Assumes state word 2i is x of branch i and word 2i+1 is its y.
module perm384_mix
    import perm384_pkg::*;
(
    input  state_t cur,
    output state_t nxt
);
    localparam int unsigned HALF = N_BR / 2;

    word_t tx, ty, lx, ly;

    // Fold of the left-half words.
    assign tx = cur[0] ^ cur[2] ^ cur[4];
    assign ty = cur[1] ^ cur[3] ^ cur[5];
    assign lx = rotr(tx ^ (tx << 16), 16);
    assign ly = rotr(ty ^ (ty << 16), 16);

    // Update each right branch and place it and its left partner in new slots.
    for (genvar j = HALF; j < N_BR; j++) begin : g_br
        localparam int unsigned NB = (j + HALF - 1) % HALF;
        assign nxt[2*NB]          = cur[2*j]   ^ ly ^ cur[2*(j-HALF)];
        assign nxt[2*NB+1]        = cur[2*j+1] ^ lx ^ cur[2*(j-HALF)+1];
        assign nxt[2*j]           = cur[2*(j-HALF)];
        assign nxt[2*j+1]         = cur[2*(j-HALF)+1];
    end
endmodule

// File: rtl/perm384_core.sv
// Module: sequential permutation core; one ARX branch per cycle, mixing on the seventh.
// Assumes start is ignored while busy; STEP_W is at least 3.
module perm384_core
    import perm384_pkg::*;
#(
    parameter int unsigned STEP_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [STEP_W-1:0]    steps,
    input  logic [STATE_W-1:0]   state_in,
    output logic [STATE_W-1:0]   state_out,
    output logic                 busy,
    output logic                 done
);
    localparam logic [2:0] MIX_PH = 3'(N_BR);

    state_t              st_q, mix_nxt;
    logic [STEP_W-1:0]   cnt_q, tgt_q, cnt_nx;
    logic [2:0]          ph_q, br;
    logic                busy_q, done_q;
    word_t               x_sel, y_sel, inj, arx_x, arx_y;

    // Branch under work; parked at 0 during the mixing cycle.
    assign br = (ph_q < MIX_PH) ? ph_q : 3'd0;

    // Step injection: table word into y0, step index into y1.
    always_comb begin
        inj = '0;
        if (ph_q == 3'd0)      inj = key_word(cnt_q[2:0]);
        else if (ph_q == 3'd1) inj = WORD_W'(cnt_q);
    end

    assign x_sel  = st_q[2*br];
    assign y_sel  = st_q[2*br+1] ^ inj;
    assign cnt_nx = cnt_q + 1'b1;

    perm384_arx_box u_arx (
        .x_in  (x_sel),
        .y_in  (y_sel),
        .key   (key_word(br)),
        .x_out (arx_x),
        .y_out (arx_y)
    );

    perm384_mix u_mix (
        .cur (st_q),
        .nxt (mix_nxt)
    );

    // Control and state register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            cnt_q  <= '0;
            tgt_q  <= '0;
            ph_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start && !busy_q) begin
            st_q   <= state_t'(state_in);
            cnt_q  <= '0;
            tgt_q  <= steps;
            ph_q   <= '0;
            busy_q <= (steps != '0);
            done_q <= (steps == '0);
        end else if (busy_q) begin
            if (ph_q < MIX_PH) begin
                st_q[2*br]   <= arx_x;
                st_q[2*br+1] <= arx_y;
                ph_q         <= ph_q + 3'd1;
            end else begin
                st_q  <= mix_nxt;
                ph_q  <= '0;
                cnt_q <= cnt_nx;
                if (cnt_nx == tgt_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign state_out = STATE_W'(st_q);
    assign busy      = busy_q;
    assign done      = done_q;
endmodule

// File: rtl/perm384_chk.sv
// Module: property checker for perm384_core, bound to every instance.
// Assumes only the top ports are visible; keeps its own busy-cycle counter.
module perm384_chk
    import perm384_pkg::*;
#(
    parameter int unsigned STEP_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [STEP_W-1:0]  steps,
    input logic [STATE_W-1:0] state_in,
    input logic [STATE_W-1:0] state_out,
    input logic               busy,
    input logic               done
);
    localparam int unsigned CW = STEP_W + 3;

    logic [CW-1:0]     cyc_q;
    logic [STEP_W-1:0] lat_q;

    // Count busy cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            lat_q <= '0;
        end else if (start && !busy) begin
            cyc_q <= '0;
            lat_q <= steps;
        end else if (busy) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R7
    AST_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && steps == '0) |=> (done && !busy && state_out == $past(state_in))); // R3
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && steps != '0) |=> (busy && !done)); // R2
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && cyc_q == CW'(lat_q) * CW'(7))); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(state_out))); // R9
    AST_BUSY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R8
endmodule

bind perm384_core perm384_chk #(.STEP_W(STEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .steps     (steps),
    .state_in  (state_in),
    .state_out (state_out),
    .busy      (busy),
    .done      (done)
);

// File: tb/perm384_core_tb_top.sv
// Bench: directed and seeded-random runs checked against a behavioural step model.
module perm384_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STEP_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [STEP_W-1:0] steps = '0;
    logic [383:0]      state_in = '0;
    logic [383:0]      state_out;
    logic              busy, done;

    int n_run = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm384_core #(.STEP_W(STEP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .steps(steps),
        .state_in(state_in), .state_out(state_out), .busy(busy), .done(done)
    );

    function automatic logic [31:0] rr(logic [31:0] v, int n);
        return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
    endfunction

    function automatic logic [31:0] tbl(int i);
        logic [31:0] t [8] = '{32'hB7E15162, 32'hBF715880, 32'h38B4DA56, 32'h324E7738,
                               32'hBB1185EB, 32'h4F7C7B57, 32'hCFBFA1C8, 32'hC2B3293D};
        return t[i % 8];
    endfunction

    function automatic logic [31:0] ellf(logic [31:0] t);
        return rr(t ^ (t << 16), 16);
    endfunction

    // Reference permutation built directly from R4, R5, R6.
    function automatic logic [383:0] model(logic [383:0] s_in, int n);
        logic [31:0] x [6];
        logic [31:0] y [6];
        logic [31:0] nx [6];
        logic [31:0] ny [6];
        logic [31:0] ax, ay, lx, ly;
        logic [383:0] r;
        for (int i = 0; i < 6; i++) begin
            x[i] = s_in[64*i +: 32];
            y[i] = s_in[64*i+32 +: 32];
        end
        for (int s = 0; s < n; s++) begin
            y[0] ^= tbl(s);
            y[1] ^= 32'(s);
            for (int i = 0; i < 6; i++) begin
                x[i] += rr(y[i], 31); y[i] ^= rr(x[i], 24); x[i] ^= tbl(i);
                x[i] += rr(y[i], 17); y[i] ^= rr(x[i], 17); x[i] ^= tbl(i);
                x[i] += y[i];         y[i] ^= rr(x[i], 31); x[i] ^= tbl(i);
                x[i] += rr(y[i], 24); y[i] ^= rr(x[i], 16); x[i] ^= tbl(i);
            end
            ax = x[0] ^ x[1] ^ x[2];
            ay = y[0] ^ y[1] ^ y[2];
            lx = ellf(ax);
            ly = ellf(ay);
            nx[2] = x[3] ^ ly ^ x[0]; ny[2] = y[3] ^ lx ^ y[0];
            nx[0] = x[4] ^ ly ^ x[1]; ny[0] = y[4] ^ lx ^ y[1];
            nx[1] = x[5] ^ ly ^ x[2]; ny[1] = y[5] ^ lx ^ y[2];
            for (int i = 0; i < 3; i++) begin
                nx[i+3] = x[i];
                ny[i+3] = y[i];
            end
            x = nx;
            y = ny;
        end
        for (int i = 0; i < 6; i++) begin
            r[64*i +: 32]    = x[i];
            r[64*i+32 +: 32] = y[i];
        end
        return r;
    endfunction

    function automatic logic [383:0] rnd_state();
        logic [383:0] v;
        for (int i = 0; i < 12; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(string req, logic ok, logic [383:0] act, logic [383:0] exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One run: start, optional ignored start mid-run, latency, result, hold.
    task automatic run(logic [383:0] s, int n, bit poke, string req);
        int lat = 0;
        logic [383:0] exp = model(s, n);
        @(negedge clk);
        state_in = s; steps = STEP_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
            start    = poke && (lat == 3);
            state_in = poke ? ~s : s;
            steps    = poke ? STEP_W'(n + 1) : STEP_W'(n);
        end
        start = 1'b0;
        check({req, " R7 latency"}, lat == 7 * n, 384'(lat), 384'(7 * n));
        check({req, " R4 R5 R6 result"}, state_out == exp, state_out, exp);
        repeat (3) @(negedge clk);
        check("R9 hold", done && !busy && state_out == exp, state_out, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [383:0] s;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check("R1 reset", !busy && !done && state_out == '0, state_out, '0);
        rst_n = 1'b1;
        // R3 zero steps: state returned unchanged.
        s = rnd_state();
        run(s, 0, 1'b0, "R3");
        check("R3 passthrough", state_out == s, state_out, s);
        // R2 single step on an all-zero state and on all ones.
        run('0, 1, 1'b0, "R2");
        run('1, 1, 1'b0, "R2");
        // R4 table wrap boundaries and R10 maximum count.
        run(rnd_state(), 7, 1'b0, "R4");
        run(rnd_state(), 8, 1'b0, "R4");
        run(rnd_state(), 11, 1'b0, "R10");
        run(rnd_state(), 15, 1'b0, "R10");
        // R8 start during a run is ignored.
        run(rnd_state(), 5, 1'b1, "R8");
        // Seeded random step counts and states.
        for (int k = 0; k < 20; k++) run(rnd_state(), int'($urandom_range(1, 15)), 1'b0, "R5");
        // R1 reset mid-run returns to idle with zero state.
        @(negedge clk);
        state_in = rnd_state(); steps = 4'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", !busy && !done && state_out == '0, state_out, '0);
        rst_n = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule